// File: doc/BRIEF.md
# Unsigned-to-Single-Precision Exception Flag Unit

This execution-unit block reports which IEEE exception flags would be raised if a 32-bit unsigned integer operand were converted to single precision. It does not produce the converted number. It produces only a 32-bit flag word, laid out like the exception field of the processor status word. No sticky status bits are touched: the block has no path to them.

An operation is issued with an operand, a guard word, a rounding-mode code and a destination tag. Three cycles later, the flag word appears together with a destination write enable and the same tag. The write enable is set only when the guard's least significant bit is 1. An unguarded operation is issued with the guard tied to 1.

The pipeline takes a new operation every cycle and has three register stages:
- Stage one captures the issue.
- Stage two finds the leading one.
- Stage three tests the bits that fall below the 24-bit significand window and encodes the flag word.

The pipeline has no states beyond these three stages. Its only transitions are the per-cycle advance from one stage to the next and the asynchronous reset, which empties every stage.

Top module: `ufx_flags`

## Requirements
- R1: Bit 1 of `wb_flags` (value 0x02, the inexact flag) is 1 exactly when, counting from the operand's leading one, some set bit lies 24 or more positions below it. Examples: 0xFFFFFFFF, 0x7FFFFFF1 and 0x01000001 give 0x02, while 0x80000000 and 0xFF000000 give 0.
- R2: An operand of 0, or any operand below 2^24, yields an all-zero flag word.
- R3: Every bit of `wb_flags` other than bit 1 reads 0. This covers overflow, underflow, invalid and divide-by-zero.
- R4: The value of `iss_rmode` (0..3) has no effect on the flag word.
- R5: An operation issued in cycle n (that is, present before the rising edge that ends cycle n) drives `wb_en`, `wb_flags` and `wb_dst` during cycle n+3.
- R6: `wb_en` is 1 only for a valid issue whose `iss_guard[0]` is 1. Bits 31..1 of the guard are ignored.
- R7: A new operation can be issued every cycle. Back-to-back operations each produce their own independent result, in issue order.
- R8: When `wb_en` is 1, `wb_dst` equals the `iss_dst` of the same operation.
- R9: While `rst_n` is low, `wb_en` is 0 and `wb_flags` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_vld | input | 1 | Operation issued this cycle |
| iss_opnd | input | 32 | Unsigned integer operand |
| iss_guard | input | 32 | Guard word; only bit 0 qualifies the write |
| iss_rmode | input | 2 | Rounding-mode code from the status word |
| iss_dst | input | 7 | Destination register tag |
| wb_en | output | 1 | Destination write enable |
| wb_dst | output | 7 | Destination tag of the result |
| wb_flags | output | 32 | Would-be exception flag word |

## Verification
Guard suppression and inexact detection can affect the same result cycle. A guard-false operation can sit directly before or after a guard-true inexact operation, so one stage holds a write that must be dropped while its neighbour holds one that must land with 0x02.

The bench provokes this with directed pairs, such as 0xFFFFFFFD with guard 0 followed by the same operand with guard 1. It also issues random operations back to back with random guard bits. In the cycle three after each issue, it checks the write enable, the tag and the flag word of that operation against a bench model.

// File: rtl/ufx_pkg.sv
package ufx_pkg;
    localparam int OPND_W  = 32;  // operand width
    localparam int SIG_W   = 24;  // significand bits incl. hidden one
    localparam int RES_W   = 32;  // flag word width
    localparam int DST_W   = 7;   // destination tag width
    localparam int INX_BIT = 1;   // inexact position in the flag word

    typedef enum logic [1:0] {
        RND_NEAREST = 2'd0,
        RND_ZERO    = 2'd1,
        RND_UP      = 2'd2,
        RND_DOWN    = 2'd3
    } rnd_mode_e;
endpackage

// File: rtl/ufx_lead_one.sv
module ufx_lead_one #(
    parameter int W     = 32,
    parameter int POS_W = $clog2(W)
) (
    input  logic [W-1:0]     vec,
    output logic [POS_W-1:0] pos,
    output logic             any
);
    always_comb begin
        pos = '0;
        any = 1'b0;
        for (int i = 0; i < W; i++) begin
            if (vec[i]) begin
                pos = POS_W'(i);
                any = 1'b1;
            end
        end
    end
endmodule

// File: rtl/ufx_tail_test.sv
module ufx_tail_test #(
    parameter int W     = 32,
    parameter int SIG_W = 24,
    parameter int POS_W = $clog2(W)
) (
    input  logic [W-1:0]     vec,
    input  logic [POS_W-1:0] pos,
    input  logic             any,
    output logic             lost
);
    logic [W-1:0] drop_mask;

    // bit i is discarded when the leading one sits SIG_W or more above it
    for (genvar i = 0; i < W; i++) begin : g_mask
        assign drop_mask[i] = (int'(pos) >= i + SIG_W);
    end

    assign lost = any & (|(vec & drop_mask));
endmodule

// File: rtl/ufx_flags.sv
module ufx_flags #(
    parameter int OPND_W  = ufx_pkg::OPND_W,
    parameter int SIG_W   = ufx_pkg::SIG_W,
    parameter int RES_W   = ufx_pkg::RES_W,
    parameter int DST_W   = ufx_pkg::DST_W,
    parameter int INX_BIT = ufx_pkg::INX_BIT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iss_vld,
    input  logic [OPND_W-1:0] iss_opnd,
    input  logic [OPND_W-1:0] iss_guard,
    input  logic [1:0]        iss_rmode,
    input  logic [DST_W-1:0]  iss_dst,
    output logic              wb_en,
    output logic [DST_W-1:0]  wb_dst,
    output logic [RES_W-1:0]  wb_flags
);
    localparam int POS_W = $clog2(OPND_W);

    // stage 1: issue capture
    logic              s1_vld, s1_wen;
    logic [DST_W-1:0]  s1_dst;
    logic [OPND_W-1:0] s1_opnd;
    ufx_pkg::rnd_mode_e s1_rmode;

    // stage 2: leading-one result
    logic              s2_vld, s2_wen, s2_any;
    logic [DST_W-1:0]  s2_dst;
    logic [OPND_W-1:0] s2_opnd;
    logic [POS_W-1:0]  s2_pos;
    ufx_pkg::rnd_mode_e s2_rmode;

    logic [POS_W-1:0]  lead_pos;
    logic              lead_any;
    logic              s2_lost;
    logic [RES_W-1:0]  flags_nxt;

    // rounding mode cannot change exactness of an integer conversion
    logic unused_sink;
    assign unused_sink = ^{iss_guard[OPND_W-1:1], s2_rmode};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_vld   <= 1'b0;
            s1_wen   <= 1'b0;
            s1_dst   <= '0;
            s1_opnd  <= '0;
            s1_rmode <= ufx_pkg::RND_NEAREST;
        end else begin
            s1_vld   <= iss_vld;
            s1_wen   <= iss_vld & iss_guard[0];
            s1_dst   <= iss_dst;
            s1_opnd  <= iss_opnd;
            s1_rmode <= ufx_pkg::rnd_mode_e'(iss_rmode);
        end
    end

    ufx_lead_one #(.W(OPND_W), .POS_W(POS_W)) u_lead (
        .vec (s1_opnd),
        .pos (lead_pos),
        .any (lead_any)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s2_vld   <= 1'b0;
            s2_wen   <= 1'b0;
            s2_any   <= 1'b0;
            s2_dst   <= '0;
            s2_opnd  <= '0;
            s2_pos   <= '0;
            s2_rmode <= ufx_pkg::RND_NEAREST;
        end else begin
            s2_vld   <= s1_vld;
            s2_wen   <= s1_wen;
            s2_any   <= lead_any;
            s2_dst   <= s1_dst;
            s2_opnd  <= s1_opnd;
            s2_pos   <= lead_pos;
            s2_rmode <= s1_rmode;
        end
    end

    ufx_tail_test #(.W(OPND_W), .SIG_W(SIG_W), .POS_W(POS_W)) u_tail (
        .vec  (s2_opnd),
        .pos  (s2_pos),
        .any  (s2_any),
        .lost (s2_lost)
    );

    always_comb begin
        flags_nxt          = '0;
        flags_nxt[INX_BIT] = s2_vld & s2_lost;
    end

    // stage 3: writeback
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wb_en    <= 1'b0;
            wb_dst   <= '0;
            wb_flags <= '0;
        end else begin
            wb_en    <= s2_wen;
            wb_dst   <= s2_dst;
            wb_flags <= flags_nxt;
        end
    end
endmodule

// File: rtl/ufx_flags_chk.sv
module ufx_flags_chk #(
    parameter int OPND_W  = 32,
    parameter int RES_W   = 32,
    parameter int DST_W   = 7,
    parameter int SIG_W   = 24,
    parameter int INX_BIT = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              iss_vld,
    input logic [OPND_W-1:0] iss_opnd,
    input logic [OPND_W-1:0] iss_guard,
    input logic [DST_W-1:0]  iss_dst,
    input logic              wb_en,
    input logic [DST_W-1:0]  wb_dst,
    input logic [RES_W-1:0]  wb_flags
);
    logic [1:0] warm;
    logic       small_op;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) warm <= 2'd0;
        else if (warm != 2'd3) warm <= warm + 2'd1;
    end

    assign small_op = (iss_opnd >> SIG_W) == '0;

    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_flags & ~(RES_W'(1) << INX_BIT)) == '0); // R3

    AST_WRITE_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd3) |-> (wb_en == $past(iss_vld & iss_guard[0], 3))); // R6

    AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd3 && !$past(iss_vld, 3)) |-> !wb_en); // R5

    AST_SMALL_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd3 && $past(iss_vld && small_op, 3)) |-> (wb_flags == '0)); // R2

    AST_DST_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd3 && wb_en) |-> (wb_dst == $past(iss_dst, 3))); // R8

    always_comb begin
        if (!rst_n) begin
            AST_RESET_QUIET: assert (!wb_en && wb_flags == '0); // R9
        end
    end
endmodule

bind ufx_flags ufx_flags_chk #(
    .OPND_W(OPND_W), .RES_W(RES_W), .DST_W(DST_W), .SIG_W(SIG_W), .INX_BIT(INX_BIT)
) i_chk (
    .clk(clk), .rst_n(rst_n), .iss_vld(iss_vld), .iss_opnd(iss_opnd),
    .iss_guard(iss_guard), .iss_dst(iss_dst), .wb_en(wb_en),
    .wb_dst(wb_dst), .wb_flags(wb_flags)
);

// File: tb/test_ufx_flags.sv
module test_ufx_flags;
    localparam int NREC = 4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        iss_vld = 1'b0;
    logic [31:0] iss_opnd = '0;
    logic [31:0] iss_guard = '0;
    logic [1:0]  iss_rmode = '0;
    logic [6:0]  iss_dst = '0;
    logic        wb_en;
    logic [6:0]  wb_dst;
    logic [31:0] wb_flags;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    logic        e_en    [NREC];
    logic [31:0] e_flags [NREC];
    logic [6:0]  e_dst   [NREC];
    string       e_tag   [NREC];

    always #4 clk = ~clk;

    ufx_flags i_ufx_flags (
        .clk(clk), .rst_n(rst_n), .iss_vld(iss_vld), .iss_opnd(iss_opnd),
        .iss_guard(iss_guard), .iss_rmode(iss_rmode), .iss_dst(iss_dst),
        .wb_en(wb_en), .wb_dst(wb_dst), .wb_flags(wb_flags)
    );

    function automatic logic [31:0] model(input logic [31:0] v);
        int  msb = -1;
        logic inx = 1'b0;
        for (int i = 0; i < 32; i++) if (v[i]) msb = i;
        for (int i = 0; i < 32; i++) if (v[i] && i + 24 <= msb) inx = 1'b1;
        return {30'b0, inx, 1'b0};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic check_slot(input int k);
        chk({e_tag[k], " R5 R6 wb_en"}, {31'b0, wb_en}, {31'b0, e_en[k]});
        if (e_en[k]) begin
            chk({e_tag[k], " flags"}, wb_flags, e_flags[k]);
            chk("R3 reserved bits", wb_flags & 32'hFFFF_FFFD, 32'h0);
            chk("R8 dst tag", {25'b0, wb_dst}, {25'b0, e_dst[k]});
        end
    endtask

    task automatic tick(input logic v, input logic [31:0] op, input logic [31:0] g,
                        input logic [1:0] rm, input string tag);
        @(negedge clk);
        if (cyc >= 3) check_slot(cyc - 3);
        iss_vld   = v;
        iss_opnd  = op;
        iss_guard = g;
        iss_rmode = rm;
        iss_dst   = 7'(cyc * 5 + 3);
        e_en[cyc]    = v & g[0];
        e_flags[cyc] = model(op);
        e_dst[cyc]   = iss_dst;
        e_tag[cyc]   = tag;
        cyc++;
    endtask

    function automatic string tag_of(input logic [31:0] op);
        return (op < 32'h0100_0000) ? "R2" : "R1";
    endfunction

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] op;
        void'($urandom(32'h5EED_0413));
        // R9: reset state
        repeat (3) begin
            @(negedge clk);
            chk("R9 reset wb_en", {31'b0, wb_en}, 32'h0);
            chk("R9 reset flags", wb_flags, 32'h0);
        end
        rst_n = 1'b1;
        // directed corners
        tick(1, 32'h0000_0003, 32'h1, 0, "R2");
        tick(1, 32'hFFFF_FFFF, 32'h1, 0, "R1");
        tick(1, 32'hFFFF_FFFD, 32'h0, 0, "R6 guard off");
        tick(1, 32'hFFFF_FFFD, 32'h1, 0, "R7 R1 after guard off");
        tick(1, 32'h7FFF_FFFF, 32'h1, 0, "R1");
        tick(1, 32'h8000_0000, 32'h1, 0, "R1 exact");
        tick(1, 32'h7FFF_FFF1, 32'h1, 0, "R1");
        tick(1, 32'h0000_0000, 32'h1, 0, "R2 zero");
        tick(1, 32'h00FF_FFFF, 32'h1, 0, "R2 max small");
        tick(1, 32'h01FF_FFFF, 32'h1, 0, "R1 one lost bit");
        tick(1, 32'h01FF_FFFE, 32'h1, 0, "R1 exact 25 bits");
        tick(1, 32'hFF00_0000, 32'h1, 0, "R1 exact high");
        tick(1, 32'hFF00_0001, 32'hFFFF_FFFE, 0, "R6 upper guard bits");
        tick(0, 32'hFFFF_FFFF, 32'h1, 0, "R6 not valid");
        tick(1, 32'hFF00_0001, 32'h3, 0, "R1");
        for (int m = 0; m < 4; m++) tick(1, 32'h0100_0001, 32'h1, 2'(m), "R4 rmode inexact");
        for (int m = 0; m < 4; m++) tick(1, 32'h4000_0000, 32'h1, 2'(m), "R4 rmode exact");
        // random back-to-back traffic
        for (int n = 0; n < 3000; n++) begin
            op = $urandom();
            op = op >> ($urandom() % 32);
            if ($urandom() % 4 == 0) op = op | 32'h1;
            tick(($urandom() % 8) != 0, op, $urandom(), 2'($urandom()),
                 {"R7 ", tag_of(op)});
        end
        repeat (4) tick(0, 32'h0, 32'h0, 0, "R5 drain");
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule